// File: doc/BRIEF.md
# Decimal Accumulator Machine Sequencer

This block is a small multicycle processor whose words are three BCD digits. The top digit of an instruction word selects the operation, and the lower two digits name one of one hundred memory locations. The machine keeps a program counter, a memory address register, a memory data register, an instruction register, an accumulator with a negative flag, and an I/O register. A hard-wired state machine runs every instruction as a fixed chain of named register transfers, one transfer per clock.

Program and data are written into the internal memory through a load port while reset is held. Reset also sets the program counter to a start address. When reset is released the machine fetches and executes instructions until it reaches a halt. A strobe loads the I/O register from outside. An output strobe marks each cycle in which the machine has just written the I/O register. The current step, the halt state and all the machine registers are visible at the ports.

Top module: `dec_acc_seq`

## Requirements
- R1: While `rst` is high: `pc` takes `pc_init`, `acc`, `neg`, `io_out` and `out_stb` are 0, `step` is 0 and `halted` is 0. A write on the load port stores `ld_data` at BCD location `ld_addr`. A write on the load port while `rst` is low has no effect on memory.
- R2: Every instruction starts with a fetch of three steps, one per clock and always in this order. Step 0 copies PC into MAR. Step 1 waits while memory is read into MDR. Step 2 copies MDR into IR and decodes it. The other step codes are: 3 address to MAR, 4 operand wait, 5 accumulator update, 6 store, 7 I/O transfer, 8 branch, 9 PC increment, 10 halted.
- R3: Opcode digit 5 (load) runs steps 3, 4, 5 and 9. It copies the word at the address digits into A, clears the flag and adds one to PC.
- R4: Opcode digit 1 (add) runs the same steps as load. It sets A to (A + word) modulo 1000 in BCD and clears the flag.
- R5: Opcode digit 2 (subtract) runs the same steps as load. It sets A to (A − word) modulo 1000 in BCD (ten's complement) and sets the flag exactly when the subtraction borrows.
- R6: Opcode digit 3 (store) runs steps 3, 6 and 9. It writes A to the addressed location and leaves A in MDR.
- R7: Word 901 copies the I/O register into A and clears the flag. Word 902 copies A into the I/O register and raises `out_stb` for exactly one cycle, during step 9. Both run step 7, then step 9. `io_in_stb` loads `io_in` into the I/O register.
- R8: Opcode digit 6 runs step 8 and loads the address digits into PC with no increment. PC changes only on leaving step 8 or step 9.
- R9: Opcode digit 7 branches when A is 000, and opcode digit 8 branches when the flag is clear. When the branch is not taken, step 8 adds one to PC.
- R10: Opcode digit 0 runs only the fetch steps and then enters step 10. `halted` goes high, and PC, A and the step stay frozen until reset.
- R11: Adding one to PC is a two-digit BCD increment that wraps from 99 to 00.
- R12: Opcode digit 4, and opcode digit 9 with address digits other than 01 or 02, run only step 9. Their only effect is the PC increment.
- R13: Start at PC 65 with 590, 192, 390 and 000 at locations 65 to 68, 111 at 90 and 222 at 92. The machine halts with A = 333, PC = 68 and location 90 holding 333.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; load port enabled |
| pc_init | input | 8 | BCD start address taken during reset |
| ld_we | input | 1 | Load port write enable (reset only) |
| ld_addr | input | 8 | Load port BCD location |
| ld_data | input | 12 | Load port BCD word |
| io_in | input | 12 | Value for the I/O register |
| io_in_stb | input | 1 | Loads `io_in` into the I/O register |
| io_out | output | 12 | I/O register |
| out_stb | output | 1 | Pulse after an output transfer |
| halted | output | 1 | Machine stopped by a halt word |
| step | output | 4 | Current step code |
| pc | output | 8 | Program counter |
| acc | output | 12 | Accumulator |
| neg | output | 1 | Borrow flag from the last subtract |
| ir | output | 12 | Instruction register |
| mar | output | 8 | Memory address register |
| mdr | output | 12 | Memory data register |

## Verification
The assertions check on every cycle that fetch steps follow one another in order, that PC moves only on leaving the branch or increment step, and that a halt stays frozen. They also check that the output strobe lasts one cycle, that MDR holds A after a store, and that a PC increment wraps to 00. Only the bench scenarios can show the arithmetic results, including BCD carry, borrow and the ten's-complement wrap. The same holds for which way each conditional branch goes, the exact step trace of a load, the reference three-instruction trace, and the fact that the load port is ignored outside reset.

// File: rtl/dec_acc_pkg.sv
package dec_acc_pkg;

  typedef enum logic [3:0] {
    ST_FMAR   = 4'd0,
    ST_FWAIT  = 4'd1,
    ST_FIR    = 4'd2,
    ST_XMAR   = 4'd3,
    ST_XWAIT  = 4'd4,
    ST_XALU   = 4'd5,
    ST_XSTORE = 4'd6,
    ST_XIO    = 4'd7,
    ST_XBR    = 4'd8,
    ST_PCINC  = 4'd9,
    ST_HALT   = 4'd10
  } step_e;

  localparam logic [3:0] OP_HALT  = 4'd0;
  localparam logic [3:0] OP_ADD   = 4'd1;
  localparam logic [3:0] OP_SUB   = 4'd2;
  localparam logic [3:0] OP_STORE = 4'd3;
  localparam logic [3:0] OP_LOAD  = 4'd5;
  localparam logic [3:0] OP_JMP   = 4'd6;
  localparam logic [3:0] OP_JZ    = 4'd7;
  localparam logic [3:0] OP_JNN   = 4'd8;
  localparam logic [3:0] OP_IO    = 4'd9;

  localparam int IO_SEL_IN  = 1;
  localparam int IO_SEL_OUT = 2;

endpackage

// File: rtl/dec_bcd_addsub.sv
module dec_bcd_addsub #(
  parameter int DIGITS = 3
) (
  input  logic [4*DIGITS-1:0] a_i,
  input  logic [4*DIGITS-1:0] b_i,
  input  logic                sub_i,
  output logic [4*DIGITS-1:0] y_o,
  output logic                carry_o
);

  logic [DIGITS:0] chain;
  assign chain[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] ad;
    logic [3:0] bd;
    logic [4:0] raw;
    logic       wrap;

    assign ad = a_i[4*g +: 4];
    assign bd = b_i[4*g +: 4];

    always_comb begin
      if (sub_i) begin
        raw  = {1'b0, ad} - {1'b0, bd} - {4'b0, chain[g]};
        wrap = raw[4];
      end else begin
        raw  = {1'b0, ad} + {1'b0, bd} + {4'b0, chain[g]};
        wrap = (raw > 5'd9);
      end
    end

    assign y_o[4*g +: 4] = wrap ? (sub_i ? raw[3:0] + 4'd10 : raw[3:0] - 4'd10)
                                : raw[3:0];
    assign chain[g+1]    = wrap;
  end

  assign carry_o = chain[DIGITS];

endmodule

// File: rtl/dec_ram.sv
module dec_ram #(
  parameter int ADDR_DIGITS = 2,
  parameter int WORD_W      = 12
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic                     re,
  input  logic [4*ADDR_DIGITS-1:0] addr,
  input  logic [WORD_W-1:0]        wdata,
  output logic [WORD_W-1:0]        rdata
);

  localparam int AW    = 4 * ADDR_DIGITS;
  localparam int DEPTH = 10 ** ADDR_DIGITS;
  localparam int IDX_W = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     lin;
  logic              in_range;

  always_comb begin
    lin = '0;
    for (int k = ADDR_DIGITS - 1; k >= 0; k--) begin
      lin = lin * AW'(10) + AW'(addr[4*k +: 4]);
    end
    in_range = (lin < AW'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (we && in_range) begin
      mem[lin[IDX_W-1:0]] <= wdata;
    end
    if (we) begin
      rdata <= wdata;
    end else if (re) begin
      rdata <= in_range ? mem[lin[IDX_W-1:0]] : '0;
    end
  end

endmodule

// File: rtl/dec_seq_ctrl.sv
module dec_seq_ctrl
  import dec_acc_pkg::*;
#(
  parameter int ADDR_DIGITS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [3:0]               mdr_op,
  input  logic [4*ADDR_DIGITS-1:0] mdr_lo,
  input  logic [3:0]               ir_op,
  input  logic                     acc_zero,
  input  logic                     neg,
  output step_e                    st_o,
  output logic                     halted_o,
  output logic                     take_o
);

  localparam int AW = 4 * ADDR_DIGITS;

  step_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FMAR:  st_d = ST_FWAIT;
      ST_FWAIT: st_d = ST_FIR;
      ST_FIR: begin
        unique case (mdr_op)
          OP_HALT:                          st_d = ST_HALT;
          OP_LOAD, OP_ADD, OP_SUB, OP_STORE: st_d = ST_XMAR;
          OP_JMP, OP_JZ, OP_JNN:            st_d = ST_XBR;
          OP_IO: begin
            if (mdr_lo == AW'(IO_SEL_IN) || mdr_lo == AW'(IO_SEL_OUT)) st_d = ST_XIO;
            else                                                       st_d = ST_PCINC;
          end
          default:                          st_d = ST_PCINC;
        endcase
      end
      ST_XMAR:   st_d = (ir_op == OP_STORE) ? ST_XSTORE : ST_XWAIT;
      ST_XWAIT:  st_d = ST_XALU;
      ST_XALU:   st_d = ST_PCINC;
      ST_XSTORE: st_d = ST_PCINC;
      ST_XIO:    st_d = ST_PCINC;
      ST_XBR:    st_d = ST_FMAR;
      ST_PCINC:  st_d = ST_FMAR;
      ST_HALT:   st_d = ST_HALT;
      default:   st_d = ST_FMAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_FMAR;
      halted_o <= 1'b0;
    end else begin
      st_q     <= st_d;
      halted_o <= (st_d == ST_HALT);
    end
  end

  always_comb begin
    unique case (ir_op)
      OP_JMP:  take_o = 1'b1;
      OP_JZ:   take_o = acc_zero;
      OP_JNN:  take_o = !neg;
      default: take_o = 1'b0;
    endcase
  end

  assign st_o = st_q;

  AST_FETCH_FIRST: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FMAR) |=> (st_q == ST_FWAIT));  // R2
  AST_FETCH_SECOND: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FWAIT) |=> (st_q == ST_FIR));   // R2
  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (st_q <= ST_HALT));                          // R2
  AST_HALT_LOCK: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> (halted_o && st_q == ST_HALT)); // R10

endmodule

// File: rtl/dec_acc_seq.sv
module dec_acc_seq
  import dec_acc_pkg::*;
#(
  parameter int ADDR_DIGITS = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [4*ADDR_DIGITS-1:0]     pc_init,
  input  logic                         ld_we,
  input  logic [4*ADDR_DIGITS-1:0]     ld_addr,
  input  logic [4*(ADDR_DIGITS+1)-1:0] ld_data,
  input  logic [4*(ADDR_DIGITS+1)-1:0] io_in,
  input  logic                         io_in_stb,
  output logic [4*(ADDR_DIGITS+1)-1:0] io_out,
  output logic                         out_stb,
  output logic                         halted,
  output logic [3:0]                   step,
  output logic [4*ADDR_DIGITS-1:0]     pc,
  output logic [4*(ADDR_DIGITS+1)-1:0] acc,
  output logic                         neg,
  output logic [4*(ADDR_DIGITS+1)-1:0] ir,
  output logic [4*ADDR_DIGITS-1:0]     mar,
  output logic [4*(ADDR_DIGITS+1)-1:0] mdr
);

  localparam int WORD_DIGITS = ADDR_DIGITS + 1;
  localparam int AW          = 4 * ADDR_DIGITS;
  localparam int WW          = 4 * WORD_DIGITS;

  step_e          st;
  logic           take;
  logic [3:0]     ir_op;
  logic [AW-1:0]  ir_lo;
  logic [WW-1:0]  alu_y;
  logic           alu_borrow;
  logic [AW-1:0]  pc_next;
  logic           pc_carry;
  logic           is_sub;
  logic           out_now;

  logic           ram_we;
  logic           ram_re;
  logic [AW-1:0]  ram_addr;
  logic [WW-1:0]  ram_wdata;

  assign ir_op   = ir[WW-1 -: 4];
  assign ir_lo   = ir[AW-1:0];
  assign is_sub  = (ir_op == OP_SUB);
  assign out_now = (st == ST_XIO) && (ir_lo == AW'(IO_SEL_OUT));

  dec_seq_ctrl #(.ADDR_DIGITS(ADDR_DIGITS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .mdr_op   (mdr[WW-1 -: 4]),
    .mdr_lo   (mdr[AW-1:0]),
    .ir_op    (ir_op),
    .acc_zero (acc == '0),
    .neg      (neg),
    .st_o     (st),
    .halted_o (halted),
    .take_o   (take)
  );

  dec_bcd_addsub #(.DIGITS(WORD_DIGITS)) u_alu (
    .a_i     (acc),
    .b_i     (mdr),
    .sub_i   (is_sub),
    .y_o     (alu_y),
    .carry_o (alu_borrow)
  );

  dec_bcd_addsub #(.DIGITS(ADDR_DIGITS)) u_pcinc (
    .a_i     (pc),
    .b_i     (AW'(1)),
    .sub_i   (1'b0),
    .y_o     (pc_next),
    .carry_o (pc_carry)
  );

  assign ram_we    = rst ? ld_we   : (st == ST_XSTORE);
  assign ram_re    = !rst && (st == ST_FWAIT || st == ST_XWAIT);
  assign ram_addr  = rst ? ld_addr : mar;
  assign ram_wdata = rst ? ld_data : acc;

  dec_ram #(.ADDR_DIGITS(ADDR_DIGITS), .WORD_W(WW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (mdr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= pc_init;
      mar     <= '0;
      ir      <= '0;
      acc     <= '0;
      neg     <= 1'b0;
      out_stb <= 1'b0;
    end else begin
      out_stb <= 1'b0;
      unique case (st)
        ST_FMAR: mar <= pc;
        ST_FIR:  ir  <= mdr;
        ST_XMAR: mar <= ir_lo;
        ST_XALU: begin
          if (ir_op == OP_LOAD) begin
            acc <= mdr;
            neg <= 1'b0;
          end else begin
            acc <= alu_y;
            neg <= is_sub && alu_borrow;
          end
        end
        ST_XIO: begin
          if (ir_lo == AW'(IO_SEL_IN)) begin
            acc <= io_out;
            neg <= 1'b0;
          end else begin
            out_stb <= 1'b1;
          end
        end
        ST_XBR:   pc <= take ? ir_lo : pc_next;
        ST_PCINC: pc <= pc_next;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_out <= '0;
    end else if (out_now) begin
      io_out <= acc;
    end else if (io_in_stb) begin
      io_out <= io_in;
    end
  end

  assign step = st;

  AST_PC_STEADY: assert property (@(posedge clk) disable iff (rst)
    (st != ST_PCINC && st != ST_XBR) |=> $stable(pc));   // R8
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(pc) && $stable(acc)));          // R10
  AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    out_stb |=> !out_stb);                               // R7
  AST_STORE_MDR: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XSTORE) |=> (mdr == $past(acc)));          // R6
  AST_PC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PCINC && pc_carry) |=> (pc == '0));        // R11

endmodule

// File: tb/test_dec_acc_seq.sv
`timescale 1ns/1ps
module test_dec_acc_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pc_init = 8'h00;
  logic        ld_we = 1'b0;
  logic [7:0]  ld_addr = 8'h00;
  logic [11:0] ld_data = 12'h000;
  logic [11:0] io_in = 12'h000;
  logic        io_in_stb = 1'b0;
  logic [11:0] io_out;
  logic        out_stb;
  logic        halted;
  logic [3:0]  step;
  logic [7:0]  pc;
  logic [11:0] acc;
  logic        neg;
  logic [11:0] ir;
  logic [7:0]  mar;
  logic [11:0] mdr;

  int checks = 0;
  int errors = 0;
  int outs   = 0;
  int out_bad = 0;

  always #2 clk = ~clk;

  dec_acc_seq i_dec_acc_seq (
    .clk(clk), .rst(rst), .pc_init(pc_init), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .io_in(io_in), .io_in_stb(io_in_stb), .io_out(io_out),
    .out_stb(out_stb), .halted(halted), .step(step), .pc(pc), .acc(acc),
    .neg(neg), .ir(ir), .mar(mar), .mdr(mdr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold_reset(input logic [7:0] start);
    @(negedge clk);
    rst = 1'b1;
    pc_init = start;
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] a, input logic [11:0] d);
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_halt(input string tag);
    int n = 0;
    outs = 0;
    out_bad = 0;
    while (!halted && n < 400) begin
      @(negedge clk);
      n++;
      if (out_stb) begin
        outs++;
        if (step != 4'd9) out_bad++;
      end
    end
    chk({tag, " halted"}, halted, 1'b1);
  endtask

  task automatic t_reset();
    hold_reset(8'h42);
    @(negedge clk);
    chk("R1 pc", pc, 8'h42);
    chk("R1 step", step, 4'd0);
    chk("R1 halted", halted, 1'b0);
    chk("R1 acc", acc, 12'h000);
    chk("R1 neg", neg, 1'b0);
    chk("R1 io", io_out, 12'h000);
    chk("R1 strobe", out_stb, 1'b0);
  endtask

  task automatic t_trace();
    int exp_steps[11] = '{0, 1, 2, 3, 4, 5, 9, 0, 1, 2, 10};
    hold_reset(8'h10);
    put(8'h10, 12'h520);
    put(8'h11, 12'h000);
    put(8'h20, 12'h042);
    release_reset();
    for (int k = 0; k < 11; k++) begin
      chk($sformatf("R2 R3 step %0d", k), step, exp_steps[k]);
      if (k < 10) @(negedge clk);
    end
    chk("R3 acc", acc, 12'h042);
    chk("R3 pc", pc, 8'h11);
    chk("R10 halted", halted, 1'b1);
  endtask

  task automatic t_reference();
    int n = 0;
    hold_reset(8'h65);
    put(8'h65, 12'h590);
    put(8'h66, 12'h192);
    put(8'h67, 12'h390);
    put(8'h68, 12'h000);
    put(8'h90, 12'h111);
    put(8'h92, 12'h222);
    release_reset();
    while (step != 4'd6 && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    chk("R6 mdr after store", mdr, 12'h333);
    run_halt("R13");
    chk("R13 acc", acc, 12'h333);
    chk("R13 pc", pc, 8'h68);
    // load port while running must not touch memory (R1)
    ld_we = 1'b1; ld_addr = 8'h90; ld_data = 12'h999;
    @(negedge clk);
    ld_we = 1'b0;
    hold_reset(8'h70);
    chk("R1 acc cleared", acc, 12'h000);
    put(8'h70, 12'h590);
    put(8'h71, 12'h000);
    release_reset();
    run_halt("R6");
    chk("R6 R13 R1 location 90", acc, 12'h333);
  endtask

  task automatic t_add_wrap();
    hold_reset(8'h30);
    put(8'h30, 12'h535);
    put(8'h31, 12'h136);
    put(8'h32, 12'h000);
    put(8'h35, 12'h999);
    put(8'h36, 12'h002);
    release_reset();
    run_halt("R4");
    chk("R4 acc", acc, 12'h001);
    chk("R4 neg", neg, 1'b0);
    chk("R4 pc", pc, 8'h32);
  endtask

  task automatic t_sub();
    hold_reset(8'h20);
    put(8'h20, 12'h530);
    put(8'h21, 12'h231);
    put(8'h22, 12'h000);
    put(8'h30, 12'h100);
    put(8'h31, 12'h250);
    release_reset();
    run_halt("R5");
    chk("R5 acc", acc, 12'h850);
    chk("R5 neg", neg, 1'b1);
  endtask

  task automatic t_branch();
    hold_reset(8'h60);
    put(8'h60, 12'h530);
    put(8'h61, 12'h231);
    put(8'h62, 12'h865);
    put(8'h63, 12'h766);
    put(8'h64, 12'h667);
    put(8'h65, 12'h000);
    put(8'h66, 12'h000);
    put(8'h67, 12'h232);
    put(8'h68, 12'h770);
    put(8'h69, 12'h000);
    put(8'h70, 12'h872);
    put(8'h71, 12'h000);
    put(8'h72, 12'h000);
    put(8'h30, 12'h100);
    put(8'h31, 12'h250);
    put(8'h32, 12'h850);
    release_reset();
    run_halt("R8 R9");
    chk("R8 R9 final pc", pc, 8'h72);
    chk("R5 zero result", acc, 12'h000);
    chk("R5 no borrow", neg, 1'b0);
  endtask

  task automatic t_io();
    hold_reset(8'h10);
    put(8'h10, 12'h901);
    put(8'h11, 12'h150);
    put(8'h12, 12'h902);
    put(8'h13, 12'h000);
    put(8'h50, 12'h111);
    release_reset();
    io_in = 12'h456; io_in_stb = 1'b1;
    @(negedge clk);
    io_in_stb = 1'b0;
    run_halt("R7");
    chk("R7 acc", acc, 12'h567);
    chk("R7 io_out", io_out, 12'h567);
    chk("R7 strobe count", outs, 1);
    chk("R7 strobe step", out_bad, 0);
  endtask

  task automatic t_halt_freeze();
    logic [7:0]  p;
    logic [11:0] a;
    p = pc; a = acc;
    repeat (20) @(negedge clk);
    chk("R10 pc frozen", pc, p);
    chk("R10 acc frozen", acc, a);
    chk("R10 step", step, 4'd10);
    chk("R10 halted", halted, 1'b1);
  endtask

  task automatic t_pc_wrap();
    hold_reset(8'h99);
    put(8'h99, 12'h501);
    put(8'h00, 12'h000);
    put(8'h01, 12'h777);
    release_reset();
    run_halt("R11");
    chk("R11 pc", pc, 8'h00);
    chk("R11 acc", acc, 12'h777);
  endtask

  task automatic t_noop();
    hold_reset(8'h80);
    put(8'h80, 12'h556);
    put(8'h81, 12'h455);
    put(8'h82, 12'h903);
    put(8'h83, 12'h000);
    put(8'h56, 12'h123);
    release_reset();
    run_halt("R12");
    chk("R12 pc", pc, 8'h83);
    chk("R12 acc", acc, 12'h123);
    chk("R12 io", io_out, 12'h000);
    chk("R12 strobe", outs, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_trace();
    t_reference();
    t_add_wrap();
    t_sub();
    t_branch();
    t_halt_freeze();
    t_io();
    t_pc_wrap();
    t_noop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule